// File: doc/BRIEF.md
# Back-EMF Step Detection Sequencer

This block runs the timed check that follows each monitored drive pulse of a bipolar stepping motor. It is started by a strobe that carries the drive direction, the pulse width code and the time-limit code. It first holds the bridge in the drive configuration for the pulse width. Then it shorts the motor, then leaves the bridge fully open to drain the stored energy. After that it opens short sense windows that alternate between two polarity configurations, with the motor shorted between windows. Two comparator flags are read at the end of each window.

The step counts as good when a positive detection is followed by a negative detection within a programmable limit. The whole check runs inside a fixed frame that starts with the drive pulse. The block reports exactly one verdict per sequence, as a one-cycle pulse. All timing advances on a `tick` strobe. With the default parameters, one tick is 1/16384 s: 16 ticks make one 0.98 ms unit, windows repeat every 8 ticks, and the frame is 512 ticks.

Top module: `step_sense_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `bridge` is 6'b000011 (both high-side switches closed, motor shorted), `sample` is 0 and both result outputs are 0. The bridge bit order is [0] high A, [1] high B, [2] low A, [3] low B, [4] sense A, [5] sense B.
- R2: `start` is taken only while idle. At that point it latches `dir`, `width_code` and `limit_code` and sets the frame position to 0. A `start` during a running sequence has no effect on the sequence.
- R3: For frame positions below TP = (width_code+1)*UNIT, `bridge` shows the drive pair: 6'b000110 (high B with low A) when dir=0, and 6'b001001 (high A with low B) when dir=1.
- R4: For the next UNIT positions `bridge` is 6'b000011 (shorted). For the UNIT positions after that it is 6'b000000 (all drive switches open).
- R5: From position TP+2*UNIT onward, every GAP-th position is a one-tick sense window with `sample`=1, and `bridge` is 6'b000011 between windows. Windows alternate, starting with phase 3. For dir=0, phase 3 is 6'b010010 (sense A with high B) and phase 4 is 6'b100001 (high A with sense B). For dir=1 the two patterns are swapped.
- R6: `pos_hit` is read only on the tick that ends a phase-3 window, and `neg_hit` only on the tick that ends a phase-4 window. Flags at any other time have no effect. A negative detection with no armed positive is ignored.
- R7: A positive detection arms the check at its position p. A later negative detection at position n with n-p <= (limit_code+4)*UNIT pulses `step_ok` for one cycle and ends the sequence.
- R8: While the armed limit is still open, further positive detections do not restart it. Once it has expired, the next positive detection re-arms at its own position.
- R9: If no success has occurred by the tick at position FRAME-1, `step_fail` pulses for one cycle and the sequence ends.
- R10: Each started sequence produces exactly one one-cycle pulse on exactly one of `step_ok` and `step_fail`.
- R11: The frame position, the pattern and the verdict advance only on clocks where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base strobe, one clock wide |
| start | input | 1 | Begin a sequence at the start of a drive pulse |
| dir | input | 1 | Drive direction of this pulse |
| width_code | input | 3 | Drive pulse width, (code+1) units |
| limit_code | input | 3 | Positive-to-negative limit, (code+4) units |
| pos_hit | input | 1 | Positive detection comparator flag |
| neg_hit | input | 1 | Negative detection comparator flag |
| bridge | output | 6 | Bridge and sense switch controls |
| sample | output | 1 | High during a sense window |
| step_ok | output | 1 | One-cycle pulse: step confirmed |
| step_fail | output | 1 | One-cycle pulse: step not confirmed in the frame |

## Verification
The assertions assume that `tick` is a single-cycle strobe and that `start` is raised only to begin a sequence. They take the comparator flags as meaningful only on the tick that closes a sense window. The stimulus holds the flags steady for a whole window cycle and, in some runs, drives both flags high in every other cycle to show that they are ignored there. Ticks arrive on every clock except in one run, which holds `tick` low for a stretch right after a start.

// File: rtl/step_sense_seq.sv
module step_sense_seq #(
  parameter int UNIT  = 16,
  parameter int GAP   = 8,
  parameter int FRAME = 512
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       dir,
  input  logic [2:0] width_code,
  input  logic [2:0] limit_code,
  input  logic       pos_hit,
  input  logic       neg_hit,
  output logic [5:0] bridge,
  output logic       sample,
  output logic       step_ok,
  output logic       step_fail
);
  localparam int TW = $clog2(FRAME);
  localparam int GB = $clog2(GAP);
  localparam int LW = $clog2(11 * UNIT + 1);

  localparam logic [5:0] SW_SHORT = 6'b000011;
  localparam logic [5:0] SW_OPEN  = 6'b000000;
  localparam logic [5:0] SW_DRV_F = 6'b000110;
  localparam logic [5:0] SW_DRV_R = 6'b001001;
  localparam logic [5:0] SW_SNS_X = 6'b010010;
  localparam logic [5:0] SW_SNS_Y = 6'b100001;

  logic          busy, dir_q;
  logic [2:0]    wc_q, lc_q;
  logic [TW-1:0] pos_t;
  logic          armed;
  logic [LW-1:0] wcnt;

  logic [TW-1:0] drive_end, short_end, open_end, rel;
  logic [LW-1:0] lim;
  logic          in_slot, is_p3, is_p4, win_open, hit_ok, at_last;

  assign drive_end = TW'((32'(wc_q) + 1) * UNIT);
  assign short_end = drive_end + TW'(UNIT);
  assign open_end  = drive_end + TW'(2 * UNIT);
  assign rel       = pos_t - open_end;
  assign lim       = LW'((32'(lc_q) + 4) * UNIT);

  assign in_slot  = busy && (pos_t >= open_end) && (rel[GB-1:0] == '0);
  assign is_p3    = in_slot && !rel[GB];
  assign is_p4    = in_slot &&  rel[GB];
  assign win_open = armed && (wcnt < lim);
  assign hit_ok   = is_p4 && neg_hit && win_open;
  assign at_last  = pos_t == TW'(FRAME - 1);
  assign sample   = in_slot;

  always_comb begin
    if (!busy)                   bridge = SW_SHORT;
    else if (pos_t < drive_end)  bridge = dir_q ? SW_DRV_R : SW_DRV_F;
    else if (pos_t < short_end)  bridge = SW_SHORT;
    else if (pos_t < open_end)   bridge = SW_OPEN;
    else if (is_p3)              bridge = dir_q ? SW_SNS_Y : SW_SNS_X;
    else if (is_p4)              bridge = dir_q ? SW_SNS_X : SW_SNS_Y;
    else                         bridge = SW_SHORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dir_q     <= 1'b0;
      wc_q      <= '0;
      lc_q      <= '0;
      pos_t     <= '0;
      armed     <= 1'b0;
      wcnt      <= '0;
      step_ok   <= 1'b0;
      step_fail <= 1'b0;
    end else begin
      step_ok   <= 1'b0;
      step_fail <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          dir_q <= dir;
          wc_q  <= width_code;
          lc_q  <= limit_code;
          pos_t <= '0;
          armed <= 1'b0;
          wcnt  <= '0;
        end
      end else if (tick) begin
        if (hit_ok) begin
          step_ok <= 1'b1;
          busy    <= 1'b0;
        end else if (at_last) begin
          step_fail <= 1'b1;
          busy      <= 1'b0;
        end else begin
          pos_t <= pos_t + 1'b1;
          if (is_p3 && pos_hit && !win_open) begin
            armed <= 1'b1;
            wcnt  <= '0;
          end else if (win_open) begin
            wcnt <= wcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/step_sense_seq_chk.sv
module step_sense_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       start,
  input logic [5:0] bridge,
  input logic       sample,
  input logic       step_ok,
  input logic       step_fail
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) !(step_ok && step_fail)); // R10
  AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) step_ok |=> !step_ok); // R10
  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n) step_fail |=> !step_fail); // R9
  AST_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (step_ok || step_fail) |-> (bridge == 6'b000011 && !sample)); // R1
  AST_SENSE_CFG: assert property (@(posedge clk) disable iff (!rst_n) sample |-> (bridge == 6'b010010 || bridge == 6'b100001)); // R5
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!tick && !start) |=> ($stable(bridge) && !step_ok && !step_fail)); // R11
endmodule

bind step_sense_seq step_sense_seq_chk u_chk (.*);

// File: tb/step_sense_seq_tb.sv
module step_sense_seq_tb;
  localparam int UNIT = 16, GAP = 8, FRAME = 512;
  localparam logic [5:0] SHORT = 6'b000011;

  logic clk = 0, rst_n = 0, tick = 0, start = 0, dir = 0, pos_hit = 0, neg_hit = 0;
  logic [2:0] width_code = 0, limit_code = 0;
  logic [5:0] bridge;
  logic sample, step_ok, step_fail;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  step_sense_seq #(.UNIT(UNIT), .GAP(GAP), .FRAME(FRAME)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .dir(dir),
    .width_code(width_code), .limit_code(limit_code), .pos_hit(pos_hit),
    .neg_hit(neg_hit), .bridge(bridge), .sample(sample),
    .step_ok(step_ok), .step_fail(step_fail));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int slot_of(input int wc, input int t);
    int base = (wc + 1) * UNIT + 2 * UNIT;
    if (t >= base && (t - base) % GAP == 0) return (t - base) / GAP;
    return -1;
  endfunction

  function automatic logic [5:0] exp_bridge(input bit d, input int wc, input int t);
    int tp = (wc + 1) * UNIT;
    int k = slot_of(wc, t);
    if (t < tp) return d ? 6'b001001 : 6'b000110;
    if (t < tp + UNIT) return SHORT;
    if (t < tp + 2 * UNIT) return 6'b000000;
    if (k < 0) return SHORT;
    if ((k % 2 == 0) ^ d) return 6'b010010;
    return 6'b100001;
  endfunction

  function automatic string tag_of(input int wc, input int t);
    int tp = (wc + 1) * UNIT;
    if (t < tp) return "R3";
    if (t < tp + 2 * UNIT) return "R4";
    return "R5";
  endfunction

  task automatic run(input bit d, input int wc, input int lc, input logic [63:0] pm,
                     input logic [63:0] nm, input int hold, input bit noise,
                     input bit poke, input string tag);
    int base = (wc + 1) * UNIT + 2 * UNIT;
    int lim = (lc + 4) * UNIT;
    bit armed = 0, exp_ok = 0;
    int tpos = 0, end_t = FRAME - 1, rc;
    for (int k = 0; base + GAP * k <= FRAME - 1; k++) begin
      int tk = base + GAP * k;
      if (k % 2 == 1) begin
        if (nm[k] && armed && tk - tpos <= lim) begin exp_ok = 1; end_t = tk; break; end
      end else if (pm[k] && !(armed && tk - tpos <= lim)) begin
        armed = 1; tpos = tk;
      end
    end
    rc = end_t + hold + 1;
    @(negedge clk);
    start = 1; dir = d; width_code = 3'(wc); limit_code = 3'(lc); tick = 0;
    pos_hit = 0; neg_hit = 0;
    @(negedge clk);
    start = 0;
    for (int c = 0; c <= rc + 1; c++) begin
      int t = (c < hold) ? 0 : c - hold;
      int k;
      if (c < rc) begin
        logic [5:0] eb = exp_bridge(d, wc, t);
        bit es = slot_of(wc, t) >= 0;
        string r = (c < hold) ? "R11" : (poke && c > 3) ? "R2" : tag_of(wc, t);
        chk(bridge == eb && sample == es && !step_ok && !step_fail, r,
            {tag, " pattern"}, {bridge, sample, step_ok, step_fail}, {eb, es, 2'b00});
      end else if (c == rc) begin
        chk(step_ok == exp_ok && step_fail == !exp_ok && bridge == SHORT && !sample,
            exp_ok ? "R7" : "R9", {tag, " verdict"}, {step_ok, step_fail, bridge},
            {exp_ok, !exp_ok, SHORT});
      end else begin
        chk(!step_ok && !step_fail && bridge == SHORT, "R10", {tag, " single verdict"},
            {step_ok, step_fail, bridge}, {2'b00, SHORT});
      end
      k = (c < rc) ? slot_of(wc, t) : -1;
      tick = (c >= hold);
      start = poke && (c == 3);
      dir = (poke && c == 3) ? ~d : d;
      if (k >= 0 && k % 2 == 0) begin pos_hit = pm[k]; neg_hit = noise; end
      else if (k >= 0) begin pos_hit = noise; neg_hit = nm[k]; end
      else begin pos_hit = noise; neg_hit = noise; end
      @(negedge clk);
    end
    start = 0; pos_hit = 0; neg_hit = 0; tick = 0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bridge == SHORT && !sample && !step_ok && !step_fail, "R1", "in reset",
        {bridge, sample}, {SHORT, 1'b0});
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(bridge == SHORT && !sample && !step_ok && !step_fail, "R1", "idle after reset",
        {bridge, sample}, {SHORT, 1'b0});

    // R3 R4 R5 R9: every width and direction, no detections -> fail
    for (int d = 0; d < 2; d++)
      for (int wc = 0; wc < 8; wc++)
        run(d[0], wc, wc ^ d, 64'd0, 64'd0, 0, 0, 0, "sweep");

    // R7: last in-limit negative passes, next one out of limit fails
    for (int lc = 0; lc < 8; lc++) begin
      int j = ((lc + 4) * UNIT) / GAP;
      if (j % 2 == 0) j--;
      run(lc[0], lc, lc, 64'd1, 64'd1 << j, 0, 0, 0, "R7 edge in");
      run(lc[0], lc, lc, 64'd1, 64'd1 << (j + 2), 0, 0, 0, "R7 edge out");
    end

    // R6: negative before positive ignored, noise elsewhere ignored
    run(0, 3, 2, 64'd1 << 2, (64'd1 << 1) | (64'd1 << 3), 0, 1, 0, "R6 neg first");
    run(1, 5, 7, 64'd0, 64'd0, 0, 1, 0, "R6 noise only");

    // R8: positive inside open limit does not restart; after expiry it re-arms
    run(0, 1, 0, (64'd1 << 0) | (64'd1 << 6), 64'd1 << 9, 0, 0, 0, "R8 no restart");
    run(1, 1, 0, (64'd1 << 0) | (64'd1 << 10), (64'd1 << 9) | (64'd1 << 11), 0, 0, 0, "R8 re-arm");

    // R11: ticks held low after start
    run(0, 2, 1, 64'd1, 64'd1 << 3, 40, 0, 0, "R11 hold");

    // R2: start during a running sequence
    run(1, 4, 3, 64'd1 << 4, 64'd1 << 7, 0, 0, 1, "R2 busy start");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule